// File: doc/BRIEF.md
# Byte-Granular Funnel Extractor

This block joins two operands into one wide value and takes a window from it. The window's position is set by a small count of bytes. It is meant to serve as one datapath slice inside a 64-bit execution unit. The second operand (`op_hi`) supplies the upper half of the joined value and the first operand (`op_lo`) supplies the lower half. The byte count `sa` moves the window downward from the top of the joined value, so a count of zero gives back the upper operand.

There are two widths. In the narrow form, only the low 32 bits of each operand take part. A 32-bit window is taken and then sign-extended to 64 bits. In the wide form, the full 128-bit join is used and a 64-bit window is returned. The selection logic is purely combinational. A single register stage with a valid flag sits behind it.

Top module: `funnel_extract`

## Requirements
- R1: With `mode_dword`=1, the result is bits [64+63−8·sa : 64−8·sa] of the 128-bit value {op_hi, op_lo}, for sa = 0 to 7.
- R2: With `mode_dword`=1 and sa=0, the result equals op_hi exactly.
- R3: With `mode_dword`=0, the value J = {op_hi[31:0], op_lo[31:0]} is formed. The 32 bits J[32+31−8·s : 32−8·s] are taken, where s = sa[1:0]. Result bit 31 is then copied into result bits 63:32.
- R4: With `mode_dword`=0 and sa[1:0]=0, the result is op_hi[31:0] sign-extended to 64 bits.
- R5: With `mode_dword`=0, sa[2] has no effect on the result.
- R6: With `mode_dword`=0, op_lo[63:32] and op_hi[63:32] have no effect on the result.
- R7: `result` and `out_valid` are updated at the first rising clock edge after a cycle with `in_valid`=1. `out_valid` is 1 only in the cycle after a cycle with `in_valid`=1.
- R8: In a cycle with `in_valid`=0, `result` keeps its previous value.
- R9: Synchronous active-high reset clears `out_valid` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode_dword | input | 1 | 1: 64-bit window, 0: 32-bit window sign-extended |
| sa | input | 3 | Byte count; only bits [1:0] are used in 32-bit mode |
| op_lo | input | 64 | First operand, lower half of the join |
| op_hi | input | 64 | Second operand, upper half of the join |
| out_valid | output | 1 | Registered result is valid (one-cycle pulse) |
| result | output | 64 | Registered extracted window |

## Verification
The bench builds the block with its default parameters: 64-bit operands and 8-bit granules. At that size every byte count is only three bits wide, so all eight values of `sa` are swept in both modes, each with random operands and fixed corner patterns. In 32-bit mode, every vector is applied a second time with sa[2] inverted and with the upper operand halves scrambled, and the result must not change. Idle cycles carrying changed inputs check that the register holds its value.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

  typedef enum logic {
    FX_NARROW = 1'b0,
    FX_WIDE   = 1'b1
  } fx_width_e;

  function automatic int fx_bytes(input int width, input int gran);
    return width / gran;
  endfunction

endpackage

// File: rtl/funnel_narrow_win.sv
// 32-bit window over the low halves of both operands, sign-extended to full width.
module funnel_narrow_win #(
  parameter  int DATA_W = 64,
  parameter  int BYTE_W = 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int NB_H   = HALF_W / BYTE_W,
  localparam int CNT_W  = (NB_H > 1) ? $clog2(NB_H) : 1
) (
  input  logic [HALF_W-1:0] lo_h,
  input  logic [HALF_W-1:0] hi_h,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] res
);

  logic [DATA_W-1:0] joined;
  logic [HALF_W-1:0] cand [NB_H];
  logic [HALF_W-1:0] pick;

  assign joined = {hi_h, lo_h};

  for (genvar k = 0; k < NB_H; k++) begin : g_cand
    assign cand[k] = joined[HALF_W - BYTE_W*k +: HALF_W];
  end

  always_comb begin
    pick = cand[cnt];
  end

  assign res = {{HALF_W{pick[HALF_W-1]}}, pick};

endmodule

// File: rtl/funnel_wide_win.sv
// Full-width window over the double-width join of both operands.
module funnel_wide_win #(
  parameter  int DATA_W = 64,
  parameter  int BYTE_W = 8,
  localparam int NB     = DATA_W / BYTE_W,
  localparam int CNT_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] res
);

  logic [2*DATA_W-1:0] joined;
  logic [DATA_W-1:0]   cand [NB];

  assign joined = {hi, lo};

  for (genvar k = 0; k < NB; k++) begin : g_cand
    assign cand[k] = joined[DATA_W - BYTE_W*k +: DATA_W];
  end

  always_comb begin
    res = cand[cnt];
  end

endmodule

// File: rtl/funnel_out_reg.sv
// Single output stage: loads on valid, holds otherwise.
module funnel_out_reg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic              vld,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      q   <= '0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end

endmodule

// File: rtl/funnel_extract.sv
module funnel_extract #(
  parameter  int DATA_W = 64,
  parameter  int BYTE_W = 8,
  localparam int NB     = funnel_pkg::fx_bytes(DATA_W, BYTE_W),
  localparam int SA_W   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              mode_dword,
  input  logic [SA_W-1:0]   sa,
  input  logic [DATA_W-1:0] op_lo,
  input  logic [DATA_W-1:0] op_hi,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  import funnel_pkg::*;

  localparam int HALF_W  = DATA_W / 2;
  localparam int NB_H    = HALF_W / BYTE_W;
  localparam int SAH_W   = (NB_H > 1) ? $clog2(NB_H) : 1;

  fx_width_e         width_sel;
  logic [DATA_W-1:0] narrow_res;
  logic [DATA_W-1:0] wide_res;
  logic [DATA_W-1:0] next_res;

  assign width_sel = fx_width_e'(mode_dword);

  funnel_narrow_win #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_narrow (
    .lo_h (op_lo[HALF_W-1:0]),
    .hi_h (op_hi[HALF_W-1:0]),
    .cnt  (sa[SAH_W-1:0]),
    .res  (narrow_res)
  );

  funnel_wide_win #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_wide (
    .lo  (op_lo),
    .hi  (op_hi),
    .cnt (sa),
    .res (wide_res)
  );

  always_comb begin
    unique case (width_sel)
      FX_WIDE:   next_res = wide_res;
      default:   next_res = narrow_res;
    endcase
  end

  funnel_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk  (clk),
    .rst  (rst),
    .load (in_valid),
    .d    (next_res),
    .vld  (out_valid),
    .q    (result)
  );

endmodule

// File: rtl/funnel_extract_chk.sv
module funnel_extract_chk #(
  parameter int DATA_W = 64,
  parameter int SA_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              mode_dword,
  input logic [SA_W-1:0]   sa,
  input logic [DATA_W-1:0] op_hi,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);

  localparam int HALF_W = DATA_W / 2;

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R2
  wide_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_dword && sa == '0) |=> result == $past(op_hi));

  // R4
  narrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_dword && sa[1:0] == 2'b00) |=>
      result == {{HALF_W{$past(op_hi[HALF_W-1])}}, $past(op_hi[HALF_W-1:0])});

  // R3
  narrow_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_dword) |=> result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}});

endmodule

bind funnel_extract funnel_extract_chk #(.DATA_W(DATA_W), .SA_W(SA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .mode_dword (mode_dword),
  .sa         (sa),
  .op_hi      (op_hi),
  .out_valid  (out_valid),
  .result     (result)
);

// File: tb/tb_funnel_extract.sv
`timescale 1ns/1ps
module tb_funnel_extract;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        mode_dword;
  logic [2:0]  sa;
  logic [63:0] op_lo, op_hi;
  logic        out_valid;
  logic [63:0] result;

  int vectors = 0;
  int errs    = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  funnel_extract dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_dword(mode_dword),
    .sa(sa), .op_lo(op_lo), .op_hi(op_hi), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(input logic wide, input logic [2:0] s,
                                        input logic [63:0] lo, input logic [63:0] hi);
    logic [127:0] cat;
    logic [31:0]  w;
    if (wide) begin
      cat = {hi, lo} >> (64 - 8*int'(s));
      return cat[63:0];
    end
    cat = {64'd0, hi[31:0], lo[31:0]} >> (32 - 8*int'(s[1:0]));
    w = cat[31:0];
    return {{32{w[31]}}, w};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic wide, input logic [2:0] s,
                       input logic [63:0] lo, input logic [63:0] hi, input string tag);
    @(negedge clk);
    in_valid = 1'b1; mode_dword = wide; sa = s; op_lo = lo; op_hi = hi;
    @(posedge clk); #1;
    check({tag, "/R7 valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, result, model(wide, s, lo, hi));
  endtask

  function automatic string tag_of(input logic wide, input logic [2:0] s);
    if (wide) return (s == 0) ? "R2" : "R1";
    if (s[2]) return "R5";
    return (s[1:0] == 0) ? "R4" : "R3";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog: actual timeout expected completion");
    errs++;
    finish_run();
  end

  initial begin
    logic [63:0] prev;
    rst = 1'b1; in_valid = 1'b0; mode_dword = 1'b0; sa = '0; op_lo = '0; op_hi = '0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check("R9 out_valid", {63'd0, out_valid}, 64'd0);
    check("R9 result", result, 64'd0);
    @(negedge clk); rst = 1'b0;

    // fixed patterns in both modes, every count
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 8; s++) begin
        apply(m[0], s[2:0], 64'h0706050403020100, 64'h8F8E8D8C8B8A8988, tag_of(m[0], s[2:0]));
        apply(m[0], s[2:0], 64'hFFFFFFFF_FFFFFFFF, 64'h0, tag_of(m[0], s[2:0]));
        apply(m[0], s[2:0], 64'h0, 64'h00000000_80000000, tag_of(m[0], s[2:0]));
      end
    end

    // random sweep over all counts and both modes
    for (int n = 0; n < 40; n++) begin
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 8; s++) begin
          logic [63:0] a, b;
          a = {$urandom, $urandom};
          b = {$urandom, $urandom};
          apply(m[0], s[2:0], a, b, tag_of(m[0], s[2:0]));
          if (m == 0) begin
            // R5: flip sa[2]; R6: scramble upper halves; result must match narrow expectation
            apply(1'b0, {~s[2], s[1:0]}, a, b, "R5");
            apply(1'b0, s[2:0], {~a[63:32], a[31:0]}, {$urandom, b[31:0]}, "R6");
            check("R6 invariance", result, model(1'b0, s[2:0], a, b));
          end
        end
      end
    end

    // R8: idle cycles with changing inputs keep result; R7: no valid pulse
    apply(1'b1, 3'd3, 64'h1122334455667788, 64'h99AABBCCDDEEFF00, "R1");
    prev = result;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b0; mode_dword = i[0]; sa = i[2:0]; op_lo = {$urandom, $urandom}; op_hi = {$urandom, $urandom};
      @(posedge clk); #1;
      check("R8 hold", result, prev);
      check("R7 idle valid", {63'd0, out_valid}, 64'd0);
    end

    // R9: reset mid-run clears state
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    check("R9 reset result", result, 64'd0);
    check("R9 reset valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;

    finish_run();
  end

endmodule